// File: doc/BRIEF.md
# USB Endpoint Handshake and Data-Toggle Controller

This block holds the control byte of one USB device endpoint and turns it into per-transaction decisions. A CPU-side port writes and reads the byte. A transaction-side port reports when a transaction starts, its direction, when the data packet went out, when the host acknowledged, and when the transaction is over. From these inputs the block picks the handshake (ACK, NAK or STALL), says whether an IN packet must be sent short, and keeps the data toggle that selects DATA0 or DATA1.

The handshake is sampled once, on the cycle the transaction starts, and is held until the next start. A CPU write that lands in the middle of a transaction therefore takes effect only from the next one. A short-packet request clears itself once its IN packet has gone out. An optional fake toggle mode lets IN transfers advance the toggle as soon as the packet is sent, without waiting for the host's ACK.

Top module: `ep_handshake_ctl`

## Requirements
- R1: The control byte is bit7 force-NAK, bit6 force-STALL, bit5 short-packet request, bit4 reserved, bit3 toggle mode, bit2 toggle status, bit1 toggle clear, bit0 toggle set. Bits 4, 1 and 0 always read 0. Bit 2 is read-only and shows the current data toggle. After reset the byte reads 0x00.
- R2: `resp_code` uses 0 for ACK, 1 for NAK and 2 for STALL. It is loaded on the cycle `txn_start` is high and holds until the next start. With no force bit set the response is ACK. With force-NAK set it is NAK.
- R3: With force-STALL set the response is STALL, even when force-NAK is also set.
- R4: A write to the force bits during a transaction is visible at once in the read data. It does not change that transaction's response, and it applies from the next start.
- R5: `send_short` is high during an IN transaction answered with ACK while bit 5 is set. Bit 5 returns to 0 when `pkt_sent` arrives in that transaction. On OUT transactions bit 5 has no effect: `send_short` stays low and the bit stays set.
- R6: A write loads bit 5 directly. A write of 1 while a request is pending leaves it pending, and this also holds when the write falls in the same cycle as the self-clear.
- R7: Writing 1 to bit 1 forces the toggle to 0, and writing 1 to bit 0 forces it to 1. If both are written as 1 together, the toggle becomes 0.
- R8: In normal mode (bit 3 = 0), `host_ack` in an ACK-answered transaction of either direction flips the toggle. `pkt_sent` alone does not flip it.
- R9: In fake mode (bit 3 = 1), `pkt_sent` flips the toggle in an IN transaction and `host_ack` is ignored there. OUT transactions still flip the toggle on `host_ack`.
- R10: In a transaction answered NAK or STALL, neither `pkt_sent` nor `host_ack` changes the toggle or clears a pending short request.
- R11: When a toggle clear or set write lands in the same cycle as a toggle-advancing event, the write decides the toggle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control byte |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Current control byte |
| txn_start | input | 1 | Transaction begins (one cycle) |
| txn_is_in | input | 1 | Direction, sampled with `txn_start` (1 = IN) |
| txn_end | input | 1 | Transaction finished (one cycle) |
| pkt_sent | input | 1 | IN data packet transmitted (one cycle) |
| host_ack | input | 1 | ACK handshake received from host (one cycle) |
| resp_code | output | 2 | Handshake for the current transaction |
| send_short | output | 1 | Send the IN packet now, whatever the FIFO level |
| data_pid_one | output | 1 | Data toggle: 0 = DATA0, 1 = DATA1 |

## Verification
Two things can hit the data toggle in one cycle: a CPU clear or set write, and a transaction event (an ACK, or a sent packet in fake mode). The bench drives `reg_wr_en` with a toggle-set byte on the same clock as `host_ack` while the toggle is already 1, and requires the toggle to stay 1, where the event alone would have flipped it to 0. The same method tests the short-packet bit: a write of 1 is placed on the cycle of the `pkt_sent` that would clear it, and the bit must read back as 1.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;
   typedef enum logic [1:0] {
      RESP_ACK   = 2'd0,
      RESP_NAK   = 2'd1,
      RESP_STALL = 2'd2
   } resp_e;

   localparam int unsigned CB_NAK   = 7;
   localparam int unsigned CB_STALL = 6;
   localparam int unsigned CB_SHORT = 5;
   localparam int unsigned CB_RSVD  = 4;
   localparam int unsigned CB_MODE  = 3;
   localparam int unsigned CB_TOG   = 2;
   localparam int unsigned CB_CLR   = 1;
   localparam int unsigned CB_SET   = 0;
endpackage

// File: rtl/ep_ctl_regs.sv
module ep_ctl_regs
   import ep_ctl_pkg::*;
#(
   parameter int unsigned CTRL_W       = 8,
   parameter bit          FAKE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              short_done,
   output logic              force_nak,
   output logic              force_stall,
   output logic              short_req,
   output logic              fake_mode,
   output logic              tog_clr,
   output logic              tog_set
);
   localparam int unsigned MIN_W = CB_NAK + 1;

   if (CTRL_W < MIN_W) begin : g_width_chk
      $error("ep_ctl_regs: CTRL_W must be at least %0d", MIN_W);
   end

   logic nak_q, stall_q, short_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nak_q   <= 1'b0;
         stall_q <= 1'b0;
         short_q <= 1'b0;
      end else begin
         if (wr_en) begin
            nak_q   <= wr_data[CB_NAK];
            stall_q <= wr_data[CB_STALL];
            short_q <= wr_data[CB_SHORT];
         end else if (short_done) begin
            short_q <= 1'b0;
         end
      end
   end

   if (FAKE_MODE_EN) begin : g_mode_reg
      logic mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     mode_q <= 1'b0;
         else if (wr_en) mode_q <= wr_data[CB_MODE];
      end
      assign fake_mode = mode_q;
   end else begin : g_mode_tied
      assign fake_mode = 1'b0;
   end

   assign force_nak   = nak_q;
   assign force_stall = stall_q;
   assign short_req   = short_q;
   assign tog_clr     = wr_en & wr_data[CB_CLR];
   assign tog_set     = wr_en & wr_data[CB_SET];

   p_short_wr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[CB_SHORT]) |=> short_req);

   p_short_selfclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (short_done && !wr_en) |=> !short_req);
endmodule

// File: rtl/ep_resp_unit.sv
module ep_resp_unit
   import ep_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       txn_start,
   input  logic       txn_is_in,
   input  logic       txn_end,
   input  logic       pkt_sent,
   input  logic       host_ack,
   input  logic       force_nak,
   input  logic       force_stall,
   input  logic       short_req,
   output logic [1:0] resp_code,
   output logic       busy_in,
   output logic       ack_evt,
   output logic       sent_evt,
   output logic       send_short,
   output logic       short_done
);
   resp_e resp_q, resp_d;
   logic  busy_q, dir_in_q;

   always_comb begin
      if (force_stall)    resp_d = RESP_STALL;
      else if (force_nak) resp_d = RESP_NAK;
      else                resp_d = RESP_ACK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_q   <= RESP_ACK;
         busy_q   <= 1'b0;
         dir_in_q <= 1'b0;
      end else if (txn_start) begin
         resp_q   <= resp_d;
         busy_q   <= 1'b1;
         dir_in_q <= txn_is_in;
      end else if (txn_end) begin
         busy_q   <= 1'b0;
      end
   end

   logic live_ack;
   assign live_ack   = busy_q && (resp_q == RESP_ACK);
   assign busy_in    = busy_q && dir_in_q;
   assign ack_evt    = live_ack && host_ack;
   assign sent_evt   = live_ack && dir_in_q && pkt_sent;
   assign send_short = live_ack && dir_in_q && short_req;
   assign short_done = sent_evt && short_req;
   assign resp_code  = resp_q;

   p_stall_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_start && force_stall) |=> (resp_code == RESP_STALL));

   p_nak_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_start && force_nak && !force_stall) |=> (resp_code == RESP_NAK));

   p_resp_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_start |=> $stable(resp_code));

   p_short_in_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      send_short |-> busy_in);

   p_no_evt_on_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_code != RESP_ACK) |-> (!ack_evt && !sent_evt));
endmodule

// File: rtl/ep_toggle_unit.sv
module ep_toggle_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic tog_clr,
   input  logic tog_set,
   input  logic fake_mode,
   input  logic busy_in,
   input  logic ack_evt,
   input  logic sent_evt,
   output logic toggle
);
   logic tog_q, advance;

   always_comb begin
      if (fake_mode && busy_in) advance = sent_evt;
      else                      advance = ack_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog_q <= 1'b0;
      else if (tog_clr) tog_q <= 1'b0;
      else if (tog_set) tog_q <= 1'b1;
      else if (advance) tog_q <= ~tog_q;
   end

   assign toggle = tog_q;

   p_clr_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tog_clr |=> !toggle);

   p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_set && !tog_clr) |=> toggle);

   p_fake_ignores_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fake_mode && busy_in && !sent_evt && !tog_clr && !tog_set) |=> $stable(toggle));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_evt && !sent_evt && !tog_clr && !tog_set) |=> $stable(toggle));
endmodule

// File: rtl/ep_handshake_ctl.sv
module ep_handshake_ctl
   import ep_ctl_pkg::*;
#(
   parameter int unsigned CTRL_W       = 8,
   parameter bit          FAKE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [CTRL_W-1:0] reg_wr_data,
   output logic [CTRL_W-1:0] reg_rd_data,
   input  logic              txn_start,
   input  logic              txn_is_in,
   input  logic              txn_end,
   input  logic              pkt_sent,
   input  logic              host_ack,
   output logic [1:0]        resp_code,
   output logic              send_short,
   output logic              data_pid_one
);
   logic force_nak, force_stall, short_req, fake_mode;
   logic tog_clr, tog_set, short_done;
   logic busy_in, ack_evt, sent_evt, toggle;

   ep_ctl_regs #(.CTRL_W(CTRL_W), .FAKE_MODE_EN(FAKE_MODE_EN)) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr_en),
      .wr_data     (reg_wr_data),
      .short_done  (short_done),
      .force_nak   (force_nak),
      .force_stall (force_stall),
      .short_req   (short_req),
      .fake_mode   (fake_mode),
      .tog_clr     (tog_clr),
      .tog_set     (tog_set)
   );

   ep_resp_unit resp_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .txn_start   (txn_start),
      .txn_is_in   (txn_is_in),
      .txn_end     (txn_end),
      .pkt_sent    (pkt_sent),
      .host_ack    (host_ack),
      .force_nak   (force_nak),
      .force_stall (force_stall),
      .short_req   (short_req),
      .resp_code   (resp_code),
      .busy_in     (busy_in),
      .ack_evt     (ack_evt),
      .sent_evt    (sent_evt),
      .send_short  (send_short),
      .short_done  (short_done)
   );

   ep_toggle_unit tog_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tog_clr   (tog_clr),
      .tog_set   (tog_set),
      .fake_mode (fake_mode),
      .busy_in   (busy_in),
      .ack_evt   (ack_evt),
      .sent_evt  (sent_evt),
      .toggle    (toggle)
   );

   always_comb begin
      reg_rd_data           = '0;
      reg_rd_data[CB_NAK]   = force_nak;
      reg_rd_data[CB_STALL] = force_stall;
      reg_rd_data[CB_SHORT] = short_req;
      reg_rd_data[CB_MODE]  = fake_mode;
      reg_rd_data[CB_TOG]   = toggle;
   end

   assign data_pid_one = toggle;

   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_data[CB_RSVD] == 1'b0) && (reg_rd_data[CB_CLR] == 1'b0) && (reg_rd_data[CB_SET] == 1'b0));
endmodule

// File: tb/ep_handshake_ctl_tb_top.sv
module ep_handshake_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wr_data = '0;
   logic [7:0] reg_rd_data;
   logic       txn_start = 1'b0, txn_is_in = 1'b0, txn_end = 1'b0;
   logic       pkt_sent = 1'b0, host_ack = 1'b0;
   logic [1:0] resp_code;
   logic       send_short, data_pid_one;

   int n_chk = 0;
   int n_fail = 0;

   always #4ns clk = ~clk;

   ep_handshake_ctl dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
      .txn_start(txn_start), .txn_is_in(txn_is_in), .txn_end(txn_end),
      .pkt_sent(pkt_sent), .host_ack(host_ack),
      .resp_code(resp_code), .send_short(send_short), .data_pid_one(data_pid_one)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   // one clock of stimulus, driven at the falling edge, released at the next
   task automatic step(input logic wr, input logic [7:0] wd, input logic st, input logic in_dir,
                       input logic en, input logic ack, input logic sent);
      @(negedge clk);
      reg_wr_en = wr; reg_wr_data = wd;
      txn_start = st; txn_is_in = in_dir; txn_end = en;
      host_ack = ack; pkt_sent = sent;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wr_data = '0;
      txn_start = 1'b0; txn_is_in = 1'b0; txn_end = 1'b0;
      host_ack = 1'b0; pkt_sent = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);  step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); endtask
   task automatic start(input logic in_dir); step(1'b0, 8'h00, 1'b1, in_dir, 1'b0, 1'b0, 1'b0); endtask
   task automatic finish_txn();             step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); endtask
   task automatic ack();                    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); endtask
   task automatic sent();                   step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); endtask

   task automatic t_reset();
      chk("R1 reset read", reg_rd_data, 8'h00);
      chk("R2 reset resp", {6'd0, resp_code}, 8'h00);
      chk("R1 reset toggle", {7'd0, data_pid_one}, 8'h00);
   endtask

   task automatic t_layout();
      wr(8'hFF);
      chk("R1 R7 all-ones write", reg_rd_data, 8'hE8);
      wr(8'h04);
      chk("R1 status read-only", reg_rd_data, 8'h00);
      wr(8'h00);
   endtask

   task automatic t_resp();
      start(1'b0);
      chk("R2 plain ACK", {6'd0, resp_code}, 8'h00);
      finish_txn();
      wr(8'h80); start(1'b0);
      chk("R2 force NAK", {6'd0, resp_code}, 8'h01);
      finish_txn();
      wr(8'hC0); start(1'b1);
      chk("R3 STALL over NAK", {6'd0, resp_code}, 8'h02);
      finish_txn();
      wr(8'h40); start(1'b0);
      chk("R3 force STALL", {6'd0, resp_code}, 8'h02);
      finish_txn();
      wr(8'h00);
   endtask

   task automatic t_hold();
      start(1'b1);
      wr(8'h80);
      chk("R4 read shows new", reg_rd_data, 8'h80);
      chk("R4 resp held", {6'd0, resp_code}, 8'h00);
      finish_txn();
      start(1'b1);
      chk("R4 next txn NAK", {6'd0, resp_code}, 8'h01);
      finish_txn();
      wr(8'h00);
   endtask

   task automatic t_short();
      wr(8'h21);
      start(1'b1);
      chk("R5 short asserted", {7'd0, send_short}, 8'h01);
      sent();
      chk("R5 short cleared", reg_rd_data, 8'h04);
      chk("R5 short out low", {7'd0, send_short}, 8'h00);
      finish_txn();
      wr(8'h20);
      start(1'b0);
      chk("R5 OUT no short", {7'd0, send_short}, 8'h00);
      ack();
      finish_txn();
      chk("R5 OUT keeps bit", {7'd0, reg_rd_data[5]}, 8'h01);
   endtask

   task automatic t_short_pend();
      wr(8'h20);
      wr(8'h20);
      chk("R6 rewrite keeps pending", {7'd0, reg_rd_data[5]}, 8'h01);
      start(1'b1);
      step(1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R6 write beats self-clear", {7'd0, reg_rd_data[5]}, 8'h01);
      finish_txn();
      wr(8'h00);
      chk("R6 write 0 clears", {7'd0, reg_rd_data[5]}, 8'h00);
   endtask

   task automatic t_normal();
      wr(8'h02);
      start(1'b1);
      sent();
      chk("R8 sent alone no flip", {7'd0, data_pid_one}, 8'h00);
      ack();
      chk("R8 IN ack flips", {7'd0, data_pid_one}, 8'h01);
      finish_txn();
      start(1'b0);
      ack();
      chk("R8 OUT ack flips", {7'd0, data_pid_one}, 8'h00);
      finish_txn();
   endtask

   task automatic t_fake();
      wr(8'h0A);
      chk("R9 mode readback", reg_rd_data, 8'h08);
      start(1'b1);
      sent();
      chk("R9 fake sent flips", {7'd0, data_pid_one}, 8'h01);
      ack();
      chk("R9 fake ignores ack", {7'd0, data_pid_one}, 8'h01);
      finish_txn();
      start(1'b0);
      ack();
      chk("R9 fake OUT on ack", {7'd0, data_pid_one}, 8'h00);
      finish_txn();
      wr(8'h00);
   endtask

   task automatic t_refused();
      wr(8'hA2);
      start(1'b1);
      chk("R10 NAK resp", {6'd0, resp_code}, 8'h01);
      chk("R10 no short on NAK", {7'd0, send_short}, 8'h00);
      sent(); ack();
      chk("R10 toggle unchanged", {7'd0, data_pid_one}, 8'h00);
      chk("R10 short kept", {7'd0, reg_rd_data[5]}, 8'h01);
      finish_txn();
      wr(8'h00);
   endtask

   task automatic t_race();
      wr(8'h01);
      start(1'b1);
      step(1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R11 set beats ack flip", {7'd0, data_pid_one}, 8'h01);
      step(1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R11 clear beats ack flip", {7'd0, data_pid_one}, 8'h00);
      finish_txn();
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_layout();
            t_resp();
            t_hold();
            t_short();
            t_short_pend();
            t_normal();
            t_fake();
            t_refused();
            t_race();
         end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule